// File: doc/BRIEF.md
# Stopped-Clock Watchdog

This block watches a monitored system clock from a separate, free-running reference clock and asks the reset controller for a reset when the monitored clock stops. It does not matter whether the clock stops high or low. Each edge of the monitored clock flips one of two flops: one for rising edges and one for falling edges. The two flops pass through a synchronizer into the reference domain. Any change there counts as activity and clears a quiet-time counter. The timeout is given in microseconds, together with the reference frequency in kHz. The block turns it into a tick limit `LIMIT = ceil(TIMEOUT_US * REF_KHZ / 1000)`.

Software sees one bit. The register decoder of a neighbouring block routes writes of bit 2 of the reset-source register to `en_wr`/`en_wdata`. Writing 1 arms the detector and writing 0 disarms it. Reading the bit returns `cause_rd`, which is 1 only after this detector caused a reset. While the device is in a low-power mode (`lp_mode` high), the detector is masked. The stored enable is not touched, so the previous setting returns on wake-up. The request goes to the reset controller and never to the external reset pin.

The controller has three states. IDLE means disarmed or masked. WATCH means counting quiet reference ticks. FIRE means the request is held. The transitions are:
- ARM (IDLE to WATCH): the detector is enabled and not masked.
- PARK (WATCH to IDLE): the detector is disabled or masked.
- TRIP (WATCH to FIRE): the quiet count reaches the limit.
- RELEASE (FIRE to IDLE): `rst_ack` is seen.

Top module: `clk_loss_monitor`

## Requirements
- R1: After `por_n` is released, `rst_req` and `cause_rd` are 0 and the detector is disabled, so a stopped clock raises no request.
- R2: While armed and not masked, if the monitored clock holds one level (high or low), `rst_req` rises. It rises no earlier than LIMIT reference cycles after the last edge and no later than LIMIT+8, where LIMIT = ceil(TIMEOUT_US*REF_KHZ/1000).
- R3: A monitored clock that keeps toggling, with a period above two reference periods, never raises `rst_req`.
- R4: A cycle with `en_wr` high stores `en_wdata` as the enable: 1 arms the detector and 0 disarms it.
- R5: While disabled, the quiet counter is held at zero. A stopped clock raises no request however long it stays stopped. After re-arming, no request comes before LIMIT cycles.
- R6: While `lp_mode` is high, no request is raised. When `lp_mode` falls, the stored enable takes effect again without a write. A detector that was disabled before the low-power mode stays disabled, and one that was enabled starts counting again.
- R7: `rst_req` stays high until `rst_ack`. After the acknowledge the counter restarts from zero, so a clock that is still stopped trips again only after at least LIMIT more cycles.
- R8: `cause_rd` becomes 1 in the cycle `rst_req` rises. It stays 1 until an `other_rst` pulse arrives while no request is held. `other_rst` is ignored while `rst_req` is high, including the cycle that carries `rst_ack`.
- R9: A trip does not clear the stored enable: the detector keeps watching after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; all state except the edge flops runs on it |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| sys_clk | input | 1 | Monitored system clock |
| lp_mode | input | 1 | High while the device is in a suspend or sleep mode |
| en_wr | input | 1 | Write strobe for the detector's register bit |
| en_wdata | input | 1 | Written value of the detector's bit (1 arms, 0 disarms) |
| other_rst | input | 1 | Pulse: a reset from another source took place |
| rst_ack | input | 1 | Reset controller accepted the request |
| rst_req | output | 1 | Reset request, held until acknowledged |
| cause_rd | output | 1 | Read value of the detector's bit: 1 if this detector caused the last reset |

## Verification
Two events can land in the same reference cycle: the reset controller's acknowledge and a clear of the cause flag by another reset source. The bench drives `rst_ack` and `other_rst` together while a request is held. It expects the request to drop and `cause_rd` to stay 1, because a pending trip owns the flag. A lone `other_rst` pulse afterwards must clear it. Random phases vary the monitored clock period, the run lengths and the stuck level around these directed cases.

// File: rtl/clm_pkg.sv
package clm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WATCH = 2'd1,
        ST_FIRE  = 2'd2
    } clm_state_e;

    // Quiet-tick limit: ceil(timeout_us * ref_khz / 1000)
    function automatic int clm_limit(input int ref_khz, input int timeout_us);
        return (ref_khz * timeout_us + 999) / 1000;
    endfunction

endpackage

// File: rtl/clm_edge_sense.sv
module clm_edge_sense #(
    parameter int STAGES = 2
) (
    input  logic sys_clk,
    input  logic ref_clk,
    input  logic rst_n,
    output logic edge_seen
);
    logic rise_t;
    logic fall_t;
    logic [1:0] chain [STAGES];
    logic [1:0] last_q;

    // flips on every rising edge of the monitored clock
    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) rise_t <= 1'b0;
        else        rise_t <= ~rise_t;
    end

    // flips on every falling edge of the monitored clock
    always_ff @(negedge sys_clk or negedge rst_n) begin
        if (!rst_n) fall_t <= 1'b0;
        else        fall_t <= ~fall_t;
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 2'b00;
        else        chain[0] <= {rise_t, fall_t};
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_sync
        always_ff @(posedge ref_clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 2'b00;
            else        chain[g] <= chain[g-1];
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) last_q <= 2'b00;
        else        last_q <= chain[STAGES-1];
    end

    assign edge_seen = |(chain[STAGES-1] ^ last_q);

    // R3: the monitored clock is slow enough that at most one flop changes per tick
    a_r3_one_edge_per_tick: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $countones(chain[STAGES-1] ^ last_q) <= 1);

endmodule

// File: rtl/clm_quiet_timer.sv
module clm_quiet_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic edge_seen,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (clr || edge_seen)  cnt_q <= '0;
        else if (cnt_q != LAST)     cnt_q <= cnt_q + 1'b1;
    end

    assign hit = (cnt_q == LAST) && !edge_seen && !clr;

    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    a_r3_edge_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> cnt_q == '0);

    a_r5_clear_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);

endmodule

// File: rtl/clm_fsm.sv
module clm_fsm
    import clm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_wr,
    input  logic en_wdata,
    input  logic lp_mode,
    input  logic hit,
    input  logic rst_ack,
    input  logic other_rst,
    output logic counting,
    output logic rst_req,
    output logic cause
);
    clm_state_e state_q, state_d;
    logic en_q;
    logic cause_q;
    logic active;
    logic trip;

    assign active = en_q && !lp_mode;
    assign trip   = (state_q == ST_WATCH) && active && hit;

    // stored enable survives low-power masking and trips
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (en_wr) en_q <= en_wdata;
    end

    // cause flag: a trip or a held request wins over another source's clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   cause_q <= 1'b0;
        else if (trip)                                cause_q <= 1'b1;
        else if (other_rst && state_q != ST_FIRE)     cause_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (active)        state_d = ST_WATCH;   // ARM
            ST_WATCH: if (!active)       state_d = ST_IDLE;    // PARK
                      else if (hit)      state_d = ST_FIRE;    // TRIP
            ST_FIRE:  if (rst_ack)       state_d = ST_IDLE;    // RELEASE
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        counting = 1'b0;
        rst_req  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_WATCH: counting = 1'b1;
            ST_FIRE:  rst_req  = 1'b1;
            default:  ;
        endcase
    end

    assign cause = cause_q;

    a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req && !rst_ack |=> rst_req);

    a_r6_lp_masks: assert property (@(posedge clk) disable iff (!rst_n)
        lp_mode && !rst_req |=> state_q != ST_WATCH);

    a_r8_cause_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> cause_q);

    a_r4_write_takes: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> en_q == $past(en_wdata));

    a_r2_trip_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(hit));

endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor
    import clm_pkg::*;
#(
    parameter int REF_KHZ     = 10000,
    parameter int TIMEOUT_US  = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic por_n,
    input  logic sys_clk,
    input  logic lp_mode,
    input  logic en_wr,
    input  logic en_wdata,
    input  logic other_rst,
    input  logic rst_ack,
    output logic rst_req,
    output logic cause_rd
);
    localparam int LIMIT = clm_limit(REF_KHZ, TIMEOUT_US);

    logic edge_seen;
    logic counting;
    logic hit;

    clm_edge_sense #(.STAGES(SYNC_STAGES)) u_edge (
        .sys_clk   (sys_clk),
        .ref_clk   (ref_clk),
        .rst_n     (por_n),
        .edge_seen (edge_seen)
    );

    clm_quiet_timer #(.LIMIT(LIMIT)) u_timer (
        .clk       (ref_clk),
        .rst_n     (por_n),
        .clr       (!counting),
        .edge_seen (edge_seen),
        .hit       (hit)
    );

    clm_fsm u_fsm (
        .clk       (ref_clk),
        .rst_n     (por_n),
        .en_wr     (en_wr),
        .en_wdata  (en_wdata),
        .lp_mode   (lp_mode),
        .hit       (hit),
        .rst_ack   (rst_ack),
        .other_rst (other_rst),
        .counting  (counting),
        .rst_req   (rst_req),
        .cause     (cause_rd)
    );

endmodule

// File: tb/test_clk_loss_monitor.sv
`timescale 1ns/1ps
module test_clk_loss_monitor;

    // 200 kHz nominal reference with a 100 us timeout gives a 20-tick window
    localparam int REF_KHZ    = 200;
    localparam int TIMEOUT_US = 100;

    function automatic int exp_limit();
        return (REF_KHZ * TIMEOUT_US + 999) / 1000;
    endfunction

    localparam int LIM = exp_limit();

    logic ref_clk = 1'b0;
    logic por_n = 1'b0;
    logic sys_clk = 1'b0;
    logic lp_mode = 1'b0;
    logic en_wr = 1'b0;
    logic en_wdata = 1'b0;
    logic other_rst = 1'b0;
    logic rst_ack = 1'b0;
    logic rst_req;
    logic cause_rd;

    int  n_chk = 0;
    int  n_fail = 0;
    int  sys_half = 13;
    bit  sys_run = 1'b1;

    clk_loss_monitor #(.REF_KHZ(REF_KHZ), .TIMEOUT_US(TIMEOUT_US), .SYNC_STAGES(2))
    i_clk_loss_monitor (
        .ref_clk(ref_clk), .por_n(por_n), .sys_clk(sys_clk), .lp_mode(lp_mode),
        .en_wr(en_wr), .en_wdata(en_wdata), .other_rst(other_rst), .rst_ack(rst_ack),
        .rst_req(rst_req), .cause_rd(cause_rd)
    );

    always #4 ref_clk = ~ref_clk;   // 125 MHz

    initial begin
        forever begin
            #(sys_half);
            if (sys_run) sys_clk = ~sys_clk;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge ref_clk);
        #2;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_en(input bit v);
        en_wr = 1'b1; en_wdata = v;
        tick(1);
        en_wr = 1'b0; en_wdata = 1'b0;
    endtask

    task automatic stop_clk(input bit level);
        do @(sys_clk); while (sys_clk !== level);
        sys_run = 1'b0;
        tick(1);
    endtask

    task automatic start_clk();
        sys_run = 1'b1;
        tick(8);
    endtask

    task automatic ack_pulse(input bit with_other);
        rst_ack = 1'b1; other_rst = with_other;
        tick(1);
        rst_ack = 1'b0; other_rst = 1'b0;
    endtask

    task automatic clear_cause();
        other_rst = 1'b1;
        tick(1);
        other_rst = 1'b0;
    endtask

    // clock already stopped: trip window check from this point
    task automatic expect_trip(input string req);
        tick(LIM - 1);
        chk({req, " no early request"}, rst_req, 0);
        tick(9);
        chk({req, " request raised"}, rst_req, 1);
        chk("R8 cause set with request", cause_rd, 1);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1357));
        tick(3);
        chk("R1 reset rst_req", rst_req, 0);
        chk("R1 reset cause_rd", cause_rd, 0);
        por_n = 1'b1;
        tick(2);

        // R1/R5: disabled after reset, stopped clock stays silent
        stop_clk(1'b0);
        tick(3 * LIM);
        chk("R1 disabled after reset", rst_req, 0);
        write_en(1'b0);
        tick(2 * LIM);
        chk("R5 disabled stays silent", rst_req, 0);

        // R5: re-arm with clock stopped, counter starts from zero
        write_en(1'b1);
        expect_trip("R5 re-arm");
        // concurrency: ack and other_rst together, flag must stay
        ack_pulse(1'b1);
        chk("R7 request drops on ack", rst_req, 0);
        chk("R8 other_rst ignored with ack", cause_rd, 1);
        // R7/R9: still stopped, still enabled -> second trip after full window
        tick(LIM - 2);
        chk("R7 no immediate retrip", rst_req, 0);
        tick(9);
        chk("R9 enable survives trip", rst_req, 1);
        tick(10);
        chk("R7 request held", rst_req, 1);
        other_rst = 1'b1; tick(1); other_rst = 1'b0;
        chk("R8 other_rst ignored while held", cause_rd, 1);
        ack_pulse(1'b0);
        start_clk();
        clear_cause();
        chk("R8 other_rst clears cause", cause_rd, 0);

        // R3/R2: random periods, run lengths and stuck levels
        for (int k = 0; k < 6; k++) begin
            int run;
            bit lvl;
            sys_half = 9 + $urandom_range(0, 14);
            run = 40 + $urandom_range(0, 120);
            lvl = $urandom_range(0, 1);
            for (int c = 0; c < run; c += 10) begin
                tick(10);
                chk("R3 toggling clock no request", rst_req, 0);
            end
            stop_clk(lvl);
            expect_trip(lvl ? "R2 stuck high" : "R2 stuck low");
            ack_pulse(1'b0);
            start_clk();
            clear_cause();
            chk("R8 cleared after random trip", cause_rd, 0);
        end

        // R4: write 0 disarms a running detector
        write_en(1'b0);
        stop_clk(1'b1);
        tick(3 * LIM);
        chk("R4 write 0 disarms", rst_req, 0);
        write_en(1'b1);
        expect_trip("R4 write 1 arms");
        ack_pulse(1'b0);
        start_clk();
        clear_cause();

        // R6: low-power masks, enable restored on wake
        lp_mode = 1'b1;
        tick(2);
        stop_clk(1'b0);
        tick(3 * LIM);
        chk("R6 masked in low power", rst_req, 0);
        lp_mode = 1'b0;
        tick(1);
        expect_trip("R6 restored enabled");
        ack_pulse(1'b0);
        start_clk();
        clear_cause();

        // R6: disabled before low power stays disabled after
        write_en(1'b0);
        lp_mode = 1'b1;
        tick(5);
        stop_clk(1'b1);
        lp_mode = 1'b0;
        tick(3 * LIM);
        chk("R6 restored disabled", rst_req, 0);
        chk("R8 cause stays clear", cause_rd, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule